// File: doc/BRIEF.md
# GPIO Bank with Dual Interrupt Lines

This block is a 32-pin general-purpose I/O bank sitting on a simple memory-mapped register bus. Software drives a per-pin output value and output enable, reads the pin inputs after a two-flop synchronizer, and selects for each pin which interrupt events it wants. The available event types are low level, high level, rising edge and falling edge, and any mix of them may be enabled on one pin. A per-pin debounce filter can be placed in the input path.

All detected events land in one shared raw event vector. Two interrupt lines read that vector, and each line has its own enable mask. Software changes a mask through separate write-one-to-set and write-one-to-clear offsets. Software clears events by writing one to a masked-status offset. It can inject events for test by writing one to a raw-status offset. An end-of-interrupt write drops the chosen line for one cycle, so that an edge-triggered interrupt controller sees a fresh edge when events are still pending. Output bits can be flipped without read-modify-write through dedicated set and clear offsets. A 64-pin system uses two instances at different bus base addresses.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pin_out`, `pin_oe` and `irq` are all zero, and the bus does not signal ready.
- R2: A write to 0x13C loads the output value. A write to 0x194 sets only the bits written as 1, and a write to 0x190 clears only those bits. Reads at 0x13C, 0x190 and 0x194 all return the current output value, which appears on `pin_out`. The register at 0x134 drives `pin_oe`.
- R3: Reading 0x138 returns the pin inputs after two-flop synchronization.
- R4: With bit i set at 0x148 (rising) or 0x14C (falling), one matching transition of the effective input sets event bit i exactly once. The opposite transition, or a steady level, sets nothing.
- R5: With bit i set at 0x144 (high) or 0x140 (low), event bit i is set every cycle the level is present. A clear therefore has no lasting effect while the level persists.
- R6: Offsets 0x24 and 0x28 both read the same shared event vector. Writing 1 to a bit at either offset sets that event, and a written 0 changes nothing.
- R7: Writing 1 to a bit at 0x2C or 0x30 clears that event in the shared vector, and a written 0 changes nothing.
- R8: Line n (0 or 1) has an enable mask. Writing 1s at 0x34/0x38 sets mask bits, and writing 1s at 0x3C/0x40 clears them. Both offsets of a line read back its mask. Offsets 0x2C/0x30 read the events ANDed with the mask, and `irq[n]` is the OR of those bits.
- R9: A write to 0x20 with data bit 0 equal to n forces `irq[n]` low for exactly the one cycle after the write. The other line is not affected.
- R10: With debounce enabled for a pin at 0x150, a new input level is accepted only after it has stayed unchanged for (0x154 value + 1) debounce ticks. Shorter pulses produce no event.
- R11: Reads at unmapped offsets return zero.
- R12: Each bus access, read or write, gets `bus_ready` high for exactly the one cycle after it is presented. Read data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completion, one cycle |
| pin_in | input | 32 | Pin input levels, asynchronous |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq | output | 2 | Interrupt lines 0 and 1 |

## Verification
The bench builds the bank with a debounce tick every 2 clocks and a 4-bit debounce time. With these settings both a rejected short pulse and an accepted stable level fit in a few dozen cycles. Pin count and bus offsets stay at their defaults, so the full 32-bit registers and both interrupt lines are exercised. The end-of-interrupt gating is checked cycle by cycle on each line in turn.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_EOI      = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_RAW0     = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_RAW1     = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_MSK0     = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_MSK1     = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_ENSET0   = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ENSET1   = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_ENCLR0   = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_ENCLR1   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_DRV_EN   = 12'h134;
  localparam logic [ADDR_W-1:0] OFS_PIN_RD   = 12'h138;
  localparam logic [ADDR_W-1:0] OFS_OUT_VAL  = 12'h13C;
  localparam logic [ADDR_W-1:0] OFS_LVL_LO   = 12'h140;
  localparam logic [ADDR_W-1:0] OFS_LVL_HI   = 12'h144;
  localparam logic [ADDR_W-1:0] OFS_EDGE_UP  = 12'h148;
  localparam logic [ADDR_W-1:0] OFS_EDGE_DN  = 12'h14C;
  localparam logic [ADDR_W-1:0] OFS_FILT_EN  = 12'h150;
  localparam logic [ADDR_W-1:0] OFS_FILT_LEN = 12'h154;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 12'h190;
  localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 12'h194;

  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int unsigned NPINS     = 32,
  parameter int unsigned DB_TIME_W = 8,
  parameter int unsigned DB_DIV    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     pin_i,
  input  logic [NPINS-1:0]     filt_en,
  input  logic [DB_TIME_W-1:0] filt_len,
  output logic [NPINS-1:0]     sync_o,
  output logic [NPINS-1:0]     eff_o
);
  localparam int unsigned DIV_W = (DB_DIV > 1) ? $clog2(DB_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DB_DIV - 1);

  logic [NPINS-1:0] meta_q, sync_q;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  // slow tick shared by all pins
  assign tick = (div_q == DIV_LAST);
  always_comb div_d = tick ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign sync_o = sync_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic                 lvl_q, lvl_d;
    logic [DB_TIME_W-1:0] cnt_q, cnt_d;

    always_comb begin
      lvl_d = lvl_q;
      cnt_d = cnt_q;
      if (!filt_en[i]) begin
        lvl_d = sync_q[i];
        cnt_d = '0;
      end else if (sync_q[i] == lvl_q) begin
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q == filt_len) begin
          lvl_d = sync_q[i];
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        lvl_q <= lvl_d;
        cnt_q <= cnt_d;
      end
    end

    assign eff_o[i] = filt_en[i] ? lvl_q : sync_q[i];
  end
endmodule

// File: rtl/gpio_evt_core.sv
module gpio_evt_core #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] eff_i,
  input  logic [NPINS-1:0] lvl_lo_en,
  input  logic [NPINS-1:0] lvl_hi_en,
  input  logic [NPINS-1:0] up_en,
  input  logic [NPINS-1:0] dn_en,
  input  logic [NPINS-1:0] sw_set,
  input  logic [NPINS-1:0] sw_clr,
  output logic [NPINS-1:0] evt_o
);
  logic [NPINS-1:0] prev_q, evt_q, evt_d, hit;

  always_comb begin
    hit = (lvl_lo_en & ~eff_i)
        | (lvl_hi_en &  eff_i)
        | (up_en     &  eff_i & ~prev_q)
        | (dn_en     & ~eff_i &  prev_q);
    // a detection in the same cycle wins over a software clear
    evt_d = (evt_q & ~sw_clr) | sw_set | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= eff_i;
      evt_q  <= evt_d;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_i,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic [NPINS-1:0] wdata,
  input  logic             eoi_hit,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] masked_o,
  output logic             irq_o
);
  logic [NPINS-1:0] mask_q, mask_d;
  logic             gate_q;

  always_comb begin
    mask_d = mask_q;
    if (en_set_we) mask_d = mask_d | wdata;
    if (en_clr_we) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gate_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      gate_q <= eoi_hit;
    end
  end

  assign mask_o   = mask_q;
  assign masked_o = evt_i & mask_q;
  assign irq_o    = (|masked_o) & ~gate_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS     = 32,
  parameter int unsigned DB_TIME_W = 8,
  parameter int unsigned DB_DIV    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              bus_ready,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [1:0]        irq
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic wr;
  assign wr = bus_sel & bus_we;

  // configuration registers
  logic [NPINS-1:0]     out_q, out_d, drv_q, drv_d;
  logic [NPINS-1:0]     llo_q, llo_d, lhi_q, lhi_d;
  logic [NPINS-1:0]     up_q, up_d, dn_q, dn_d;
  logic [NPINS-1:0]     fen_q, fen_d;
  logic [DB_TIME_W-1:0] flen_q, flen_d;
  logic [NPINS-1:0]     rdata_q, rdata_d;
  logic                 ready_q;

  logic [NPINS-1:0] sync_in, eff_in, raw_evt, sw_set, sw_clr;
  logic [NPINS-1:0] line_mask   [NUM_LINES];
  logic [NPINS-1:0] line_masked [NUM_LINES];
  logic [NPINS-1:0] en_mask0, en_mask1;
  logic [1:0]       en_set_we, en_clr_we, eoi_hit;

  always_comb begin
    out_d  = out_q;
    drv_d  = drv_q;
    llo_d  = llo_q;
    lhi_d  = lhi_q;
    up_d   = up_q;
    dn_d   = dn_q;
    fen_d  = fen_q;
    flen_d = flen_q;
    sw_set = '0;
    sw_clr = '0;
    en_set_we = 2'b00;
    en_clr_we = 2'b00;
    eoi_hit   = 2'b00;
    if (wr) begin
      case (bus_addr)
        OFS_OUT_VAL:  out_d  = bus_wdata;
        OFS_OUT_SET:  out_d  = out_q | bus_wdata;
        OFS_OUT_CLR:  out_d  = out_q & ~bus_wdata;
        OFS_DRV_EN:   drv_d  = bus_wdata;
        OFS_LVL_LO:   llo_d  = bus_wdata;
        OFS_LVL_HI:   lhi_d  = bus_wdata;
        OFS_EDGE_UP:  up_d   = bus_wdata;
        OFS_EDGE_DN:  dn_d   = bus_wdata;
        OFS_FILT_EN:  fen_d  = bus_wdata;
        OFS_FILT_LEN: flen_d = bus_wdata[DB_TIME_W-1:0];
        OFS_RAW0, OFS_RAW1: sw_set = bus_wdata;
        OFS_MSK0, OFS_MSK1: sw_clr = bus_wdata;
        OFS_ENSET0:   en_set_we[0] = 1'b1;
        OFS_ENSET1:   en_set_we[1] = 1'b1;
        OFS_ENCLR0:   en_clr_we[0] = 1'b1;
        OFS_ENCLR1:   en_clr_we[1] = 1'b1;
        OFS_EOI:      eoi_hit = bus_wdata[0] ? 2'b10 : 2'b01;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        OFS_RAW0, OFS_RAW1:     rdata_d = raw_evt;
        OFS_MSK0:               rdata_d = line_masked[0];
        OFS_MSK1:               rdata_d = line_masked[1];
        OFS_ENSET0, OFS_ENCLR0: rdata_d = line_mask[0];
        OFS_ENSET1, OFS_ENCLR1: rdata_d = line_mask[1];
        OFS_DRV_EN:             rdata_d = drv_q;
        OFS_PIN_RD:             rdata_d = sync_in;
        OFS_OUT_VAL, OFS_OUT_SET, OFS_OUT_CLR: rdata_d = out_q;
        OFS_LVL_LO:             rdata_d = llo_q;
        OFS_LVL_HI:             rdata_d = lhi_q;
        OFS_EDGE_UP:            rdata_d = up_q;
        OFS_EDGE_DN:            rdata_d = dn_q;
        OFS_FILT_EN:            rdata_d = fen_q;
        OFS_FILT_LEN:           rdata_d = NPINS'(flen_q);
        default:                rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q   <= '0;
      drv_q   <= '0;
      llo_q   <= '0;
      lhi_q   <= '0;
      up_q    <= '0;
      dn_q    <= '0;
      fen_q   <= '0;
      flen_q  <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      drv_q   <= drv_d;
      llo_q   <= llo_d;
      lhi_q   <= lhi_d;
      up_q    <= up_d;
      dn_q    <= dn_d;
      fen_q   <= fen_d;
      flen_q  <= flen_d;
      rdata_q <= rdata_d;
      ready_q <= bus_sel;
    end
  end

  gpio_in_filter #(
    .NPINS(NPINS), .DB_TIME_W(DB_TIME_W), .DB_DIV(DB_DIV)
  ) u_filter (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(pin_in),
    .filt_en(fen_q), .filt_len(flen_q),
    .sync_o(sync_in), .eff_o(eff_in)
  );

  gpio_evt_core #(.NPINS(NPINS)) u_evt (
    .clk(clk), .rst_n(rst_sync_n), .eff_i(eff_in),
    .lvl_lo_en(llo_q), .lvl_hi_en(lhi_q), .up_en(up_q), .dn_en(dn_q),
    .sw_set(sw_set), .sw_clr(sw_clr), .evt_o(raw_evt)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    gpio_irq_line #(.NPINS(NPINS)) u_line (
      .clk(clk), .rst_n(rst_sync_n), .evt_i(raw_evt),
      .en_set_we(en_set_we[n]), .en_clr_we(en_clr_we[n]),
      .wdata(bus_wdata), .eoi_hit(eoi_hit[n]),
      .mask_o(line_mask[n]), .masked_o(line_masked[n]), .irq_o(irq[n])
    );
  end

  assign en_mask0  = line_mask[0];
  assign en_mask1  = line_mask[1];
  assign bus_rdata = rdata_q;
  assign bus_ready = ready_q;
  assign pin_out   = out_q;
  assign pin_oe    = drv_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_ready,
  input logic [NPINS-1:0]  pin_out,
  input logic [1:0]        irq,
  input logic [NPINS-1:0]  raw_evt,
  input logic [NPINS-1:0]  en_mask0,
  input logic [NPINS-1:0]  en_mask1
);
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready); // R12

  AST_READY_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && $past(rst_n)) |-> $past(bus_sel)); // R12

  AST_IRQ0_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> (|(raw_evt & en_mask0))); // R8

  AST_IRQ1_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> (|(raw_evt & en_mask1))); // R8

  AST_EOI0_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_EOI && !bus_wdata[0]) |=> !irq[0]); // R9

  AST_EOI1_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_EOI && bus_wdata[0]) |=> !irq[1]); // R9

  AST_OUT_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_OUT_SET)
      |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_OUT_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_OUT_CLR)
      |=> ((pin_out & $past(bus_wdata)) == '0)); // R2
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .pin_out(pin_out), .irq(irq), .raw_evt(raw_evt),
  .en_mask0(en_mask0), .en_mask1(en_mask1)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        bus_ready;
  logic [1:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // scoreboard: one entry per bus access
  bit          chk_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  gpio_irq_bank #(.NPINS(32), .DB_TIME_W(4), .DB_DIV(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops one expected item per completed access
  always @(negedge clk) begin
    if (rst_n && bus_ready) begin
      if (chk_q.size() == 0) begin
        check("R12 unexpected ready", 32'd1, 32'd0);
      end else begin
        automatic bit          c = chk_q.pop_front();
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        if (c) check(t, bus_rdata, e);
      end
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    chk_q.push_back(1'b0); exp_q.push_back('0); tag_q.push_back("");
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, logic [31:0] e, string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    chk_q.push_back(1'b1); exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 32'd1, 32'd0);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 ready idle", {31'd0, bus_ready}, 32'd0);
    check("R1 pin_out", pin_out, 32'd0);
    check("R1 pin_oe", pin_oe, 32'd0);
    check("R1 irq", {30'd0, irq}, 32'd0);
    bus_rd(12'h13C, 32'd0, "R1 out value");
    bus_rd(12'h024, 32'd0, "R1 raw events");
    bus_rd(12'h034, 32'd0, "R1 mask0");
    bus_rd(12'h154, 32'd0, "R1 filter length");

    // R2 output value, set/clear without read-modify-write
    bus_wr(12'h13C, 32'hA5A5_0000);
    bus_rd(12'h13C, 32'hA5A5_0000, "R2 out load");
    bus_wr(12'h194, 32'h0000_00FF);
    bus_rd(12'h194, 32'hA5A5_00FF, "R2 out set");
    bus_wr(12'h190, 32'hA000_0001);
    bus_rd(12'h190, 32'h05A5_00FE, "R2 out clear");
    bus_wr(12'h134, 32'hFFFF_0000);
    check("R2 pin_out", pin_out, 32'h05A5_00FE);
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);

    // R3 synchronized input
    pin_in = 32'h1234_5678;
    idle(3);
    bus_rd(12'h138, 32'h1234_5678, "R3 pin read");

    // R11 unmapped offsets
    bus_rd(12'h000, 32'd0, "R11 offset 0x000");
    bus_rd(12'h100, 32'd0, "R11 offset 0x100");
    bus_rd(12'h020, 32'd0, "R11 offset 0x020");

    // R4 edges: rising on pin 0, falling on pin 1
    pin_in = '0;
    idle(4);
    bus_wr(12'h148, 32'h1);
    bus_wr(12'h14C, 32'h2);
    pin_in[0] = 1'b1;
    idle(5);
    bus_rd(12'h024, 32'h1, "R4 rising event");
    bus_wr(12'h02C, 32'h1);
    idle(3);
    bus_rd(12'h024, 32'h0, "R4 rising fires once");
    pin_in[1] = 1'b1;
    idle(5);
    bus_rd(12'h024, 32'h0, "R4 rise ignored on fall pin");
    pin_in[1] = 1'b0;
    idle(5);
    bus_rd(12'h028, 32'h2, "R4 falling event / R6 shared vector");
    bus_wr(12'h030, 32'h2);
    bus_rd(12'h024, 32'h0, "R7 clear through line 1");

    // R6 software set, R7 write-zero has no effect
    bus_wr(12'h024, 32'h8000_0000);
    bus_wr(12'h028, 32'h0);
    bus_rd(12'h024, 32'h8000_0000, "R6 set and zero ignored");
    bus_wr(12'h02C, 32'h0);
    bus_rd(12'h028, 32'h8000_0000, "R7 zero clear ignored");
    bus_wr(12'h02C, 32'h8000_0000);
    bus_rd(12'h024, 32'h0, "R7 clear");

    // R5 levels: high on pin 4, low on pin 7
    bus_wr(12'h144, 32'h10);
    pin_in[4] = 1'b1;
    idle(5);
    bus_rd(12'h024, 32'h10, "R5 high level");
    bus_wr(12'h02C, 32'h10);
    bus_rd(12'h024, 32'h10, "R5 level re-asserts");
    pin_in[4] = 1'b0;
    idle(4);
    bus_wr(12'h02C, 32'h10);
    bus_rd(12'h024, 32'h0, "R5 clear after level gone");
    bus_wr(12'h140, 32'h80);
    idle(2);
    bus_rd(12'h024, 32'h80, "R5 low level");
    bus_wr(12'h140, 32'h0);
    bus_wr(12'h02C, 32'h80);
    bus_rd(12'h024, 32'h0, "R5 low level cleared");

    // R8 masks and lines
    bus_wr(12'h024, 32'h3);
    check("R8 irq with masks off", {30'd0, irq}, 32'd0);
    bus_wr(12'h034, 32'h1);
    bus_wr(12'h038, 32'h2);
    check("R8 both lines", {30'd0, irq}, 32'd3);
    bus_rd(12'h02C, 32'h1, "R8 masked line 0");
    bus_rd(12'h030, 32'h2, "R8 masked line 1");
    bus_rd(12'h03C, 32'h1, "R8 mask0 via clear offset");
    bus_rd(12'h040, 32'h2, "R8 mask1 via clear offset");
    bus_wr(12'h03C, 32'h1);
    check("R8 line 0 masked off", {30'd0, irq}, 32'd2);
    bus_rd(12'h034, 32'h0, "R8 mask0 cleared");
    bus_wr(12'h034, 32'h1);

    // R9 end of interrupt, one line at a time
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h020; bus_wdata = 32'h0;
    chk_q.push_back(1'b0); exp_q.push_back('0); tag_q.push_back("");
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R9 line 0 gap", {30'd0, irq}, 32'd2);
    @(negedge clk);
    check("R9 line 0 back", {30'd0, irq}, 32'd3);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h020; bus_wdata = 32'h1;
    chk_q.push_back(1'b0); exp_q.push_back('0); tag_q.push_back("");
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R9 line 1 gap", {30'd0, irq}, 32'd1);
    @(negedge clk);
    check("R9 line 1 back", {30'd0, irq}, 32'd3);
    bus_wr(12'h02C, 32'hFFFF_FFFF);
    check("R7 clear drops lines", {30'd0, irq}, 32'd0);

    // R10 debounce on pin 9 with length 2 (3 ticks)
    bus_wr(12'h148, 32'h0);
    bus_wr(12'h14C, 32'h0);
    bus_wr(12'h154, 32'h2);
    bus_wr(12'h150, 32'h200);
    bus_wr(12'h148, 32'h200);
    pin_in[9] = 1'b1;
    idle(2);
    pin_in[9] = 1'b0;
    idle(20);
    bus_rd(12'h024, 32'h0, "R10 short pulse rejected");
    pin_in[9] = 1'b1;
    idle(30);
    bus_rd(12'h024, 32'h200, "R10 stable level accepted");

    idle(3);
    check("R12 all accesses answered", chk_q.size(), 32'd0);
    done = 1'b1;
    summary();
  end
endmodule